// File: doc/BRIEF.md
# Multichannel Serial Audio Input Port

This block gathers audio from up to eight serial input lanes. Each lane has its own bit clock, frame sync and data pin. It merges the received words into one small shared FIFO that a single consumer reads. Each lane treats a frame as 64 bits and splits it into two 32-bit words, the left word first and then the right word. Three framing formats are supported, chosen by a shared format input. Every word that leaves the FIFO carries the number of the lane it came from and a flag that marks it as a left or right word.

All lane pins are brought into the system clock domain through plain flip-flop synchronizers. Each bit clock is then treated as a sampled signal, so the system clock must run several times faster than the fastest bit clock. When several lanes finish a word in the same cycle, a fixed-priority arbiter writes them into the FIFO one per cycle. Each lane can hold one word that has not yet been written. As a build-time option, the highest lane can be switched at run time to a 20-bit parallel capture path, which is sampled on the rising edge of a strobe.

Top module: `audin_port`

## Requirements
- R1: Each lane assembles a 64-bit frame into two 32-bit words, received MSB first. The first word of the frame is the left word. Each FIFO word comes out with its lane number on `rd_chan_o` and its slot on `rd_right_o`, where 0 means left and 1 means right.
- R2: When `fmt_i` is 2'b01 (left-justified; 2'b11 behaves the same), a half-frame is left while frame sync is high. Its MSB is the bit sampled on the bit-clock rising edge at which frame sync changes level.
- R3: When `fmt_i` is 2'b00 (I2S), a half-frame is left while frame sync is low. Its MSB is sampled one bit clock after the edge at which frame sync changes level.
- R4: When `fmt_i` is 2'b10 (right-justified), framing is the same as in R2. Each word keeps only the last 24 bits of its half-frame, and bits 31:24 read as zero.
- R5: The shared FIFO is 32 bits wide and eight words deep. It delivers words in the order they were written and presents them on `rd_data_o` while `rd_valid_o` is high, and `rd_ready_i` pops one word. While the FIFO is full, finished words wait in their lane's holding register and none is lost.
- R6: When several lanes are waiting in the same cycle, the lowest-numbered lane is written into the FIFO first.
- R7: If a lane finishes a word while its holding register is still occupied, the new word is discarded and bit n of `ovf_o` is set for that lane. The bit stays set until reset.
- R8: With `par_sel_i` high, lane 7 ignores its serial pins. Each rising edge of `pstb_i` captures `pdata_i` into bits 19:0 of a FIFO word, with bits 31:20 zero, lane number 7 and slot flag 0.
- R9: A strobe held high captures once. Changes to `pdata_i` while `pstb_i` stays high produce no further word.
- R10: After reset the FIFO is empty (`rd_valid_o` low) and `ovf_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Frame format: 00 I2S, 01/11 left-justified, 10 right-justified |
| par_sel_i | input | 1 | Lane 7 takes words from the parallel capture path |
| sclk_i | input | 8 | Bit clock per lane |
| fsync_i | input | 8 | Frame sync per lane |
| sdata_i | input | 8 | Serial data per lane |
| pstb_i | input | 1 | Parallel capture strobe |
| pdata_i | input | 20 | Parallel capture data |
| rd_ready_i | input | 1 | Consumer pops the head word |
| rd_valid_o | output | 1 | FIFO holds at least one word |
| rd_data_o | output | 32 | Head word |
| rd_chan_o | output | 3 | Lane number of the head word |
| rd_right_o | output | 1 | Head word is a right word |
| ovf_o | output | 8 | Sticky per-lane word-loss flags |

## Verification
A serial word reaches the FIFO about four system cycles after the bit-clock rising edge that carries its last bit: two synchronizer stages, one edge-detect register, the holding register, and then the FIFO write. A parallel word follows the rising edge of the strobe after the same number of stages. The scoreboard does not wait for a fixed cycle. It pops words as `rd_valid_o` shows them and matches each one against the oldest expected word with the same lane number, so legal interleaving between lanes is accepted. Status checks are taken at least twenty cycles after the stimulus that causes them, which is well past that latency. Ordering across lanes is checked only where R6 fixes it: all lanes are started in lockstep while the consumer is stalled.

// File: rtl/audin_pkg.sv
package audin_pkg;
   typedef enum logic [1:0] {
      FMT_I2S  = 2'b00,
      FMT_LJ   = 2'b01,
      FMT_RJ   = 2'b10,
      FMT_LJ_B = 2'b11
   } fmt_e;
endpackage

// File: rtl/audin_sync.sv
module audin_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("audin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/audin_deser.sv
module audin_deser
   import audin_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int RJ_BITS = 24
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  fmt_e              fmt_i,
   input  logic              bclk_i,
   input  logic              fs_i,
   input  logic              sd_i,
   output logic              emit_o,
   output logic [WORD_W-1:0] word_o,
   output logic              right_o
);
   localparam int CW = $clog2(WORD_W) + 1;
   localparam logic [WORD_W-1:0] RJ_MASK = {{(WORD_W-RJ_BITS){1'b0}}, {RJ_BITS{1'b1}}};

   if (RJ_BITS < 1 || RJ_BITS >= WORD_W) begin : g_bad_rj
      $error("audin_deser: RJ_BITS must lie between 1 and WORD_W-1");
   end

   logic              bclk_q, fs_prev_q, eff_prev_q, active_q, right_q;
   logic [CW-1:0]     cnt_q;
   logic [WORD_W-1:0] shreg_q;

   logic              rise, is_i2s, eff_fs, fs_chg, left_now, last_bit;
   logic [WORD_W-1:0] full_word;

   always_comb begin
      rise      = bclk_i & ~bclk_q;
      is_i2s    = (fmt_i == FMT_I2S);
      eff_fs    = is_i2s ? fs_prev_q : fs_i;
      fs_chg    = eff_fs ^ eff_prev_q;
      left_now  = is_i2s ? ~eff_fs : eff_fs;
      full_word = {shreg_q[WORD_W-2:0], sd_i};
      last_bit  = active_q && (cnt_q == CW'(WORD_W - 1));
   end

   assign emit_o  = rise && !fs_chg && last_bit;
   assign word_o  = (fmt_i == FMT_RJ) ? (full_word & RJ_MASK) : full_word;
   assign right_o = right_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bclk_q     <= 1'b0;
         fs_prev_q  <= 1'b0;
         eff_prev_q <= 1'b0;
         active_q   <= 1'b0;
         right_q    <= 1'b0;
         cnt_q      <= '0;
         shreg_q    <= '0;
      end else begin
         bclk_q <= bclk_i;
         if (rise) begin
            fs_prev_q  <= fs_i;
            eff_prev_q <= eff_fs;
            if (fs_chg) begin
               shreg_q  <= {{(WORD_W-1){1'b0}}, sd_i};
               cnt_q    <= CW'(1);
               active_q <= 1'b1;
               right_q  <= ~left_now;
            end else if (active_q) begin
               shreg_q <= full_word;
               cnt_q   <= cnt_q + CW'(1);
               if (last_bit) active_q <= 1'b0;
            end
         end
      end
   end

   // R1: the bit counter never runs past one word
   p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(WORD_W));
endmodule

// File: rtl/audin_slot.sv
module audin_slot #(
   parameter int WIDTH = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_word_i,
   input  logic             load_right_i,
   input  logic             take_i,
   output logic             valid_o,
   output logic [WIDTH-1:0] word_o,
   output logic             right_o,
   output logic             ovf_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         word_o  <= '0;
         right_o <= 1'b0;
         ovf_o   <= 1'b0;
      end else if (load_i && valid_o && !take_i) begin
         ovf_o <= 1'b1;
      end else if (load_i) begin
         valid_o <= 1'b1;
         word_o  <= load_word_i;
         right_o <= load_right_i;
      end else if (take_i) begin
         valid_o <= 1'b0;
      end
   end

   p_hold_until_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !take_i) |=> (valid_o && $stable(word_o) && $stable(right_o)));

   p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |=> ovf_o);

   p_take_needs_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |-> valid_o);
endmodule

// File: rtl/audin_arb.sv
module audin_arb #(
   parameter int N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] req_i,
   input  logic         allow_i,
   output logic [N-1:0] grant_o
);
   always_comb begin
      logic found;
      found   = 1'b0;
      grant_o = '0;
      for (int i = 0; i < N; i++) begin
         if (allow_i && req_i[i] && !found) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   p_single_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant_o));

   p_grant_has_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o & ~req_i) == '0);

   for (genvar g = 1; g < N; g++) begin : g_prio_chk
      p_lower_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         grant_o[g] |-> (req_i[g-1:0] == '0));
   end
endmodule

// File: rtl/audin_fifo.sv
module audin_fifo #(
   parameter int WIDTH = 36,
   parameter int DEPTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             rd_i,
   output logic [WIDTH-1:0] rdata_o,
   output logic             valid_o,
   output logic             full_o
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("audin_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
   logic [AW:0]      count_q;
   logic             push, pop;

   assign valid_o = (count_q != '0);
   assign full_o  = (count_q == (AW+1)'(DEPTH));
   assign push    = wr_i && !full_o;
   assign pop     = rd_i && valid_o;
   assign rdata_o = mem_q[rd_ptr_q];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_q + AW'(1);
         if (pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
         case ({push, pop})
            2'b10:   count_q <= count_q + (AW+1)'(1);
            2'b01:   count_q <= count_q - (AW+1)'(1);
            default: count_q <= count_q;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (push) mem_q[wr_ptr_q] <= wdata_i;
   end

   p_wr_when_room_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |-> !full_o);

   p_idle_stays_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_o && !wr_i) |=> !valid_o);

   p_count_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_q <= (AW+1)'(DEPTH));
endmodule

// File: rtl/audin_port.sv
module audin_port
   import audin_pkg::*;
#(
   parameter int N_CH        = 8,
   parameter int WORD_W      = 32,
   parameter int FIFO_DEPTH  = 8,
   parameter int PAR_W       = 20,
   parameter int RJ_BITS     = 24,
   parameter int SYNC_STAGES = 2,
   parameter bit PAR_EN      = 1'b1
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [1:0]                fmt_i,
   input  logic                      par_sel_i,
   input  logic [N_CH-1:0]           sclk_i,
   input  logic [N_CH-1:0]           fsync_i,
   input  logic [N_CH-1:0]           sdata_i,
   input  logic                      pstb_i,
   input  logic [PAR_W-1:0]          pdata_i,
   input  logic                      rd_ready_i,
   output logic                      rd_valid_o,
   output logic [WORD_W-1:0]         rd_data_o,
   output logic [$clog2(N_CH)-1:0]   rd_chan_o,
   output logic                      rd_right_o,
   output logic [N_CH-1:0]           ovf_o
);
   localparam int TW = $clog2(N_CH);
   localparam int EW = TW + 1 + WORD_W;

   if (N_CH < 2) begin : g_bad_nch
      $error("audin_port: N_CH must be at least 2");
   end
   if (PAR_W > WORD_W) begin : g_bad_parw
      $error("audin_port: PAR_W must not exceed WORD_W");
   end

   fmt_e fmt_sel;
   assign fmt_sel = fmt_e'(fmt_i);

   logic [N_CH-1:0]   slot_valid, slot_right, grant;
   logic [WORD_W-1:0] slot_word [N_CH];
   logic              fifo_full;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic [2:0]        pins_s;
      logic              ser_emit, ser_right;
      logic [WORD_W-1:0] ser_word;
      logic              ld, ld_right;
      logic [WORD_W-1:0] ld_word;

      audin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    ({sclk_i[c], fsync_i[c], sdata_i[c]}),
         .q_o    (pins_s)
      );

      audin_deser #(.WORD_W(WORD_W), .RJ_BITS(RJ_BITS)) u_deser (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .fmt_i   (fmt_sel),
         .bclk_i  (pins_s[2]),
         .fs_i    (pins_s[1]),
         .sd_i    (pins_s[0]),
         .emit_o  (ser_emit),
         .word_o  (ser_word),
         .right_o (ser_right)
      );

      if (PAR_EN && c == N_CH - 1) begin : g_par
         logic [PAR_W:0] par_s;
         logic           stb_q, par_emit;

         audin_sync #(.WIDTH(PAR_W + 1), .STAGES(SYNC_STAGES)) u_psync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    ({pstb_i, pdata_i}),
            .q_o    (par_s)
         );

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stb_q <= 1'b0;
            else         stb_q <= par_s[PAR_W];
         end

         assign par_emit = par_s[PAR_W] & ~stb_q;
         assign ld       = par_sel_i ? par_emit : ser_emit;
         assign ld_word  = par_sel_i ? {{(WORD_W-PAR_W){1'b0}}, par_s[PAR_W-1:0]} : ser_word;
         assign ld_right = par_sel_i ? 1'b0 : ser_right;

         // R9: a held strobe cannot yield two captures in a row
         p_one_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            par_emit |=> !par_emit);
      end else begin : g_ser
         assign ld       = ser_emit;
         assign ld_word  = ser_word;
         assign ld_right = ser_right;
      end

      audin_slot #(.WIDTH(WORD_W)) u_slot (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .load_i       (ld),
         .load_word_i  (ld_word),
         .load_right_i (ld_right),
         .take_i       (grant[c]),
         .valid_o      (slot_valid[c]),
         .word_o       (slot_word[c]),
         .right_o      (slot_right[c]),
         .ovf_o        (ovf_o[c])
      );
   end

   audin_arb #(.N(N_CH)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (slot_valid),
      .allow_i (!fifo_full),
      .grant_o (grant)
   );

   logic [EW-1:0] wr_entry, rd_entry;

   always_comb begin
      wr_entry = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (grant[c]) wr_entry = {TW'(c), slot_right[c], slot_word[c]};
      end
   end

   audin_fifo #(.WIDTH(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (|grant),
      .wdata_i (wr_entry),
      .rd_i    (rd_ready_i),
      .rdata_o (rd_entry),
      .valid_o (rd_valid_o),
      .full_o  (fifo_full)
   );

   assign rd_chan_o  = rd_entry[EW-1 -: TW];
   assign rd_right_o = rd_entry[WORD_W];
   assign rd_data_o  = rd_entry[WORD_W-1:0];
endmodule

// File: tb/tb_audin_port.sv
`timescale 1ns/1ps
module tb_audin_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt = 2'b01;
   logic        par_sel = 1'b0;
   logic [7:0]  sclk = '0, fsync = '0, sdata = '0;
   logic        pstb = 1'b0;
   logic [19:0] pdata = '0;
   logic        rd_ready = 1'b0;
   logic        rd_valid, rd_right;
   logic [31:0] rd_data;
   logic [2:0]  rd_chan;
   logic [7:0]  ovf;

   audin_port dut (
      .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .par_sel_i(par_sel),
      .sclk_i(sclk), .fsync_i(fsync), .sdata_i(sdata),
      .pstb_i(pstb), .pdata_i(pdata), .rd_ready_i(rd_ready),
      .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_chan_o(rd_chan),
      .rd_right_o(rd_right), .ovf_o(ovf)
   );

   always #2 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   logic [35:0] exp_q[$];
   logic [31:0] rng = 32'h1234_5678;
   bit drain = 1'b0;
   int pop_tag [64];
   int pop_rt  [64];
   int pop_n = 0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   function automatic logic [31:0] next_rand();
      rng = rng * 32'd1664525 + 32'd1013904223;
      return rng ^ {rng[15:0], rng[31:16]};
   endfunction

   // one bit-clock period: pins change while clock is low, then rise
   task automatic edge_out(input logic [7:0] mask, input logic [7:0] fsv, input logic [7:0] sdv);
      @(negedge clk);
      fsync = (fsync & ~mask) | (fsv & mask);
      sdata = (sdata & ~mask) | (sdv & mask);
      repeat (4) @(negedge clk);
      sclk = sclk | mask;
      repeat (4) @(negedge clk);
      sclk = sclk & ~mask;
   endtask

   task automatic send(input logic [7:0] mask, input logic [7:0] pmask, input int nfr,
                       input logic [1:0] f);
      logic [63:0] frame [8];
      logic [7:0]  fsv, sdv, prev;
      logic [31:0] lw, rw;
      prev = '0;
      edge_out(mask, (f == 2'b00) ? 8'hFF : 8'h00, 8'h00);
      for (int fr = 0; fr < nfr; fr++) begin
         for (int ch = 0; ch < 8; ch++) begin
            frame[ch] = {next_rand(), next_rand()};
            lw = frame[ch][63:32];
            rw = frame[ch][31:0];
            if (f == 2'b10) begin   // R4: keep last 24 bits
               lw = lw & 32'h00FF_FFFF;
               rw = rw & 32'h00FF_FFFF;
            end
            if (pmask[ch]) begin
               exp_q.push_back({3'(ch), 1'b0, lw});
               exp_q.push_back({3'(ch), 1'b1, rw});
            end
         end
         for (int e = 0; e < 64; e++) begin
            for (int ch = 0; ch < 8; ch++) begin
               if (f == 2'b00) begin
                  fsv[ch] = (e >= 32);
                  if (e == 0) sdv[ch] = prev[ch];
                  else        sdv[ch] = frame[ch][64-e];
               end else begin
                  fsv[ch] = (e < 32);
                  sdv[ch] = frame[ch][63-e];
               end
            end
            edge_out(mask, fsv, sdv);
         end
         for (int ch = 0; ch < 8; ch++) prev[ch] = frame[ch][0];
      end
      if (f == 2'b00) edge_out(mask, 8'h00, prev);
   endtask

   task automatic par_word(input logic [19:0] d);
      @(negedge clk);
      pdata = d;
      exp_q.push_back({3'd7, 1'b0, 12'h000, d});
      repeat (3) @(negedge clk);
      pstb = 1'b1;
      repeat (8) @(negedge clk);
      pdata = ~d;            // R9: no capture while strobe held
      repeat (8) @(negedge clk);
      pstb = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic wait_drain(input string req);
      drain = 1'b1;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (exp_q.size() == 0 && !rd_valid) break;
      end
      repeat (4) @(negedge clk);
      check({req, " all expected words delivered"}, 64'(exp_q.size()), 64'd0);
      check({req, " FIFO empty after drain"}, 64'(rd_valid), 64'd0);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (drain && rd_valid) begin
            int found;
            found = -1;
            for (int i = 0; i < exp_q.size(); i++) begin
               if (exp_q[i][35:33] == rd_chan) begin
                  found = i;
                  break;
               end
            end
            if (pop_n < 64) begin
               pop_tag[pop_n] = int'(rd_chan);
               pop_rt[pop_n]  = int'(rd_right);
               pop_n++;
            end
            if (found < 0) begin
               n_chk++;
               n_fail++;
               $display("FAIL R1/R8 unexpected word: actual chan %0d data %0h expected none",
                        rd_chan, rd_data);
            end else begin
               check("R1 word slot and data", {rd_right, rd_data}, {exp_q[found][32], exp_q[found][31:0]});
               exp_q.delete(found);
            end
            rd_ready = 1'b1;
         end else begin
            rd_ready = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (5) @(negedge clk);
      check("R10 reset FIFO empty", 64'(rd_valid), 64'd0);
      check("R10 reset overflow clear", 64'(ovf), 64'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      drain = 1'b1;

      fmt = 2'b01;                                  // R2 left-justified
      send(8'h05, 8'h05, 3, 2'b01);
      wait_drain("R2");

      fmt = 2'b00;                                  // R3 I2S
      send(8'h72, 8'h72, 3, 2'b00);
      wait_drain("R3");

      fmt = 2'b10;                                  // R4 right-justified
      send(8'h18, 8'h18, 2, 2'b10);
      wait_drain("R4");
      check("R7 no overflow in normal traffic", 64'(ovf), 64'd0);

      // R6 priority and R5 backpressure: all lanes in lockstep, consumer stalled
      fmt = 2'b01;
      drain = 1'b0;
      pop_n = 0;
      send(8'hFF, 8'hFF, 1, 2'b01);
      repeat (20) @(negedge clk);
      check("R5 words held while stalled", 64'(rd_valid), 64'd1);
      check("R5 no loss when FIFO full", 64'(ovf), 64'd0);
      wait_drain("R5");
      check("R6 pop count", 64'(pop_n), 64'd16);
      for (int k = 0; k < 16; k++) begin
         check("R6 ascending lane order", 64'(pop_tag[k]), 64'(k % 8));
         check("R1 left words before right", 64'(pop_rt[k]), 64'(k / 8));
      end

      // R7 overflow: lane 3 sends ten words into eight FIFO entries plus one holding slot
      drain = 1'b0;
      send(8'h08, 8'h08, 5, 2'b01);
      void'(exp_q.pop_back());
      repeat (20) @(negedge clk);
      check("R7 overflow flag on lane 3 only", 64'(ovf), 64'h08);
      wait_drain("R7");
      check("R7 overflow flag sticky", 64'(ovf), 64'h08);

      // R8 parallel mode: lane 7 serial pins ignored, lane 0 serial still works
      par_sel = 1'b1;
      send(8'h81, 8'h01, 2, 2'b01);
      wait_drain("R8 serial lane 7 ignored");
      par_word(20'hABCDE);
      par_word(20'h00001);
      par_word(20'hFFFFF);
      wait_drain("R9");

      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R10 reset clears overflow", 64'(ovf), 64'd0);
      check("R10 reset empties FIFO", 64'(rd_valid), 64'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      summary();
   end
endmodule